// File: doc/BRIEF.md
# Mode-Steered Banked Register File

This block holds thirty-one 64-bit general registers and a program counter, and serves two views of that storage. The 64-bit view addresses the entries directly by a 5-bit slot number. The 32-bit view uses a 4-bit register number (R0 to R15). The current processor mode, taken from the low five bits of the status word, steers that number onto a physical slot. The registers that are private to a mode live in fixed slots of the 64-bit file. A change of mode therefore only changes which slots R8 to R14 reach, and no data is copied.

The 32-bit view has two combinational read ports and one write port. The 64-bit view has one combinational read port and one write port that share an index. Every port accepts a request in every cycle and never stalls, so there is no back-pressure and no ready signal. A write enable qualifies each write, and reads are always valid. A mode value outside the eight defined encodings raises a flag. While that flag is up, the 32-bit view is fenced off.

Top module: `mode_banked_rf`

## Requirements
- R1: In every legal mode, 32-bit registers R0 to R7 reach 64-bit slots 0 to 7 with the same number.
- R2: In every legal mode other than FIQ, R8 to R12 reach slots 8 to 12. In FIQ mode (5'h11), R8 to R14 reach slots 24 to 30, in that order.
- R3: R13 and R14 reach the following slots: USR (5'h10) and SYS (5'h1F) slots 13 and 14; HYP (5'h1A) slots 15 and 14; IRQ (5'h12) slots 16 and 17; SVC (5'h13) slots 18 and 19; ABT (5'h17) slots 20 and 21; UND (5'h1B) slots 22 and 23.
- R4: In every legal mode, R15 is the program counter. On the 64-bit port, slot index 31 addresses that same program counter.
- R5: The legal mode encodings are exactly 5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1A, 5'h1B and 5'h1F. `illegal_mode_o` is 1 for any other value and 0 for these.
- R6: While the mode is illegal, both 32-bit read ports return zero and a 32-bit write changes no slot and not the program counter.
- R7: A 32-bit write stores its data zero-extended into bits 63:32. A 32-bit read returns bits 31:0 of the selected slot.
- R8: Writes take effect at the rising clock edge and reads are combinational. A read of a slot in the same cycle as a write to it returns the value from before the write.
- R9: When both write ports hit the same slot in one cycle, the 64-bit write wins.
- R10: A synchronous active-low reset clears all 31 slots and the program counter to zero.
- R11: A change of `mode_i` alters which slot a 32-bit read reaches in the same cycle, with no clock edge in between and no change to any stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 5 | Processor mode field that steers the 32-bit view |
| illegal_mode_o | output | 1 | Set while `mode_i` holds an undefined encoding |
| ra_idx_i | input | 4 | 32-bit read port A register number |
| ra_data_o | output | 32 | 32-bit read port A data |
| rb_idx_i | input | 4 | 32-bit read port B register number |
| rb_data_o | output | 32 | 32-bit read port B data |
| w32_en_i | input | 1 | 32-bit write enable |
| w32_idx_i | input | 4 | 32-bit write register number |
| w32_data_i | input | 32 | 32-bit write data |
| x_idx_i | input | 5 | 64-bit port slot index (31 selects the program counter) |
| x_we_i | input | 1 | 64-bit write enable |
| x_wdata_i | input | 64 | 64-bit write data |
| x_rdata_o | output | 64 | 64-bit read data for `x_idx_i` |

## Verification
In each of the eight modes, the bench writes a value to every 32-bit register number, and each value encodes the mode and the register. Reading all 64-bit slots afterwards then exposes any register steered into another mode's bank, and any slot that a shared register should have overwritten but did not. Before the sweep, every slot is preloaded with ones in its upper half, so a missing zero-extension is caught. Further tests switch the mode between two reads with no clock edge, issue a read and a write to the same slot in one cycle, send both write ports to one slot at once, and drive undefined mode values. These tests separate combinational steering from registered steering, and write-first from read-first behaviour, and they confirm that the 32-bit view is fenced off while the mode is illegal.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int XLEN      = 64;
  localparam int WLEN      = 32;
  localparam int MODE_W    = 5;
  localparam int A32_IDX_W = 4;
  localparam int SLOT_W    = 5;
  localparam int NUM_SLOTS = 1 << SLOT_W;
  localparam int PC_SLOT   = NUM_SLOTS - 1;

  localparam int FIRST_BANKED = 8;
  localparam int SP_IDX       = 13;
  localparam int LR_IDX       = 14;
  localparam int PC_IDX       = 15;
  localparam int FIQ_BASE     = 24;
  localparam int FIQ_OFFSET   = FIQ_BASE - FIRST_BANKED;

  typedef enum logic [MODE_W-1:0] {
    M_USR = 5'h10,
    M_FIQ = 5'h11,
    M_IRQ = 5'h12,
    M_SVC = 5'h13,
    M_ABT = 5'h17,
    M_HYP = 5'h1A,
    M_UND = 5'h1B,
    M_SYS = 5'h1F
  } cpu_mode_e;

  typedef struct packed {
    logic              legal;
    logic              fiq;
    logic [SLOT_W-1:0] sp_slot;
    logic [SLOT_W-1:0] lr_slot;
  } bank_sel_t;
endpackage

// File: rtl/rf_mode_decode.sv
module rf_mode_decode
  import rf_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output bank_sel_t         sel_o
);
  always_comb begin
    sel_o.legal   = 1'b1;
    sel_o.fiq     = 1'b0;
    sel_o.sp_slot = SLOT_W'(SP_IDX);
    sel_o.lr_slot = SLOT_W'(LR_IDX);
    case (mode_i)
      M_USR, M_SYS: ;
      M_FIQ: begin
        sel_o.fiq     = 1'b1;
        sel_o.sp_slot = SLOT_W'(SP_IDX + FIQ_OFFSET);
        sel_o.lr_slot = SLOT_W'(LR_IDX + FIQ_OFFSET);
      end
      M_HYP: sel_o.sp_slot = SLOT_W'(15);
      M_IRQ: begin
        sel_o.sp_slot = SLOT_W'(16);
        sel_o.lr_slot = SLOT_W'(17);
      end
      M_SVC: begin
        sel_o.sp_slot = SLOT_W'(18);
        sel_o.lr_slot = SLOT_W'(19);
      end
      M_ABT: begin
        sel_o.sp_slot = SLOT_W'(20);
        sel_o.lr_slot = SLOT_W'(21);
      end
      M_UND: begin
        sel_o.sp_slot = SLOT_W'(22);
        sel_o.lr_slot = SLOT_W'(23);
      end
      default: sel_o.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/rf_steer.sv
module rf_steer
  import rf_pkg::*;
(
  input  logic [A32_IDX_W-1:0] idx_i,
  input  bank_sel_t            sel_i,
  output logic [SLOT_W-1:0]    slot_o
);
  logic [SLOT_W-1:0] idx_ext;
  assign idx_ext = SLOT_W'(idx_i);

  always_comb begin
    if (idx_ext < SLOT_W'(FIRST_BANKED))
      slot_o = idx_ext;
    else if (idx_ext < SLOT_W'(SP_IDX))
      slot_o = sel_i.fiq ? idx_ext + SLOT_W'(FIQ_OFFSET) : idx_ext;
    else if (idx_ext == SLOT_W'(SP_IDX))
      slot_o = sel_i.sp_slot;
    else if (idx_ext == SLOT_W'(LR_IDX))
      slot_o = sel_i.lr_slot;
    else
      slot_o = SLOT_W'(PC_SLOT);
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage
  import rf_pkg::*;
#(
  parameter int DEPTH = NUM_SLOTS,
  parameter int DW    = XLEN,
  parameter int NW    = WLEN,
  parameter int AW    = SLOT_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      n_we_i,
  input  logic [AW-1:0]             n_slot_i,
  input  logic [NW-1:0]             n_wdata_i,
  input  logic                      w_we_i,
  input  logic [AW-1:0]             w_slot_i,
  input  logic [DW-1:0]             w_wdata_i,
  input  logic [AW-1:0]             rd0_slot_i,
  input  logic [AW-1:0]             rd1_slot_i,
  input  logic [AW-1:0]             rdw_slot_i,
  output logic [NW-1:0]             rd0_data_o,
  output logic [NW-1:0]             rd1_data_o,
  output logic [DW-1:0]             rdw_data_o,
  output logic [DEPTH-1:0][DW-1:0]  mem_o
);
  localparam int PAD = DW - NW;

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic [DW-1:0] q;
    logic          hit_w, hit_n;
    assign hit_w = w_we_i && (w_slot_i == AW'(e));
    assign hit_n = n_we_i && (n_slot_i == AW'(e));
    always_ff @(posedge clk) begin
      if (!rst_n)     q <= '0;
      else if (hit_w) q <= w_wdata_i;
      else if (hit_n) q <= {{PAD{1'b0}}, n_wdata_i};
    end
    assign mem_o[e] = q;
  end

  assign rd0_data_o = mem_o[rd0_slot_i][NW-1:0];
  assign rd1_data_o = mem_o[rd1_slot_i][NW-1:0];
  assign rdw_data_o = mem_o[rdw_slot_i];
endmodule

// File: rtl/mode_banked_rf.sv
module mode_banked_rf
  import rf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [MODE_W-1:0]    mode_i,
  output logic                 illegal_mode_o,
  input  logic [A32_IDX_W-1:0] ra_idx_i,
  output logic [WLEN-1:0]      ra_data_o,
  input  logic [A32_IDX_W-1:0] rb_idx_i,
  output logic [WLEN-1:0]      rb_data_o,
  input  logic                 w32_en_i,
  input  logic [A32_IDX_W-1:0] w32_idx_i,
  input  logic [WLEN-1:0]      w32_data_i,
  input  logic [SLOT_W-1:0]    x_idx_i,
  input  logic                 x_we_i,
  input  logic [XLEN-1:0]      x_wdata_i,
  output logic [XLEN-1:0]      x_rdata_o
);
  localparam int NPORT = 3;

  bank_sel_t                       sel;
  logic [NPORT-1:0][A32_IDX_W-1:0] p_idx;
  logic [NPORT-1:0][SLOT_W-1:0]    p_slot;
  logic [WLEN-1:0]                 rd_a, rd_b;
  logic [NUM_SLOTS-1:0][XLEN-1:0]  mem_w;

  rf_mode_decode u_dec (.mode_i(mode_i), .sel_o(sel));

  assign p_idx[0] = ra_idx_i;
  assign p_idx[1] = rb_idx_i;
  assign p_idx[2] = w32_idx_i;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    rf_steer u_steer (.idx_i(p_idx[p]), .sel_i(sel), .slot_o(p_slot[p]));
  end

  rf_storage u_store (
    .clk(clk), .rst_n(rst_n),
    .n_we_i(w32_en_i && sel.legal), .n_slot_i(p_slot[2]), .n_wdata_i(w32_data_i),
    .w_we_i(x_we_i), .w_slot_i(x_idx_i), .w_wdata_i(x_wdata_i),
    .rd0_slot_i(p_slot[0]), .rd1_slot_i(p_slot[1]), .rdw_slot_i(x_idx_i),
    .rd0_data_o(rd_a), .rd1_data_o(rd_b), .rdw_data_o(x_rdata_o),
    .mem_o(mem_w)
  );

  assign illegal_mode_o = !sel.legal;
  assign ra_data_o      = sel.legal ? rd_a : '0;
  assign rb_data_o      = sel.legal ? rd_b : '0;
endmodule

// File: rtl/rf_checker.sv
module rf_checker
  import rf_pkg::*;
(
  input logic                          clk,
  input logic                          rst_n,
  input logic                          illegal,
  input logic                          w32_en,
  input logic [A32_IDX_W-1:0]          w32_idx,
  input logic                          x_we,
  input logic [A32_IDX_W-1:0]          ra_idx,
  input logic [WLEN-1:0]               ra_data,
  input logic [NUM_SLOTS-1:0][XLEN-1:0] mem
);
  a_r10_reset_clears: assert property (@(posedge clk)
    !rst_n |=> mem == '0);

  a_r6_illegal_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal && !x_we) |=> $stable(mem));

  a_r6_illegal_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> ra_data == '0);

  a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!illegal && w32_en && !x_we && w32_idx < A32_IDX_W'(FIRST_BANKED))
      |=> mem[$past(w32_idx)][XLEN-1:WLEN] == '0);

  a_r1_low_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (!illegal && ra_idx < A32_IDX_W'(FIRST_BANKED))
      |-> ra_data == mem[ra_idx][WLEN-1:0]);

  a_r4_pc_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (!illegal && ra_idx == A32_IDX_W'(PC_IDX))
      |-> ra_data == mem[PC_SLOT][WLEN-1:0]);
endmodule

bind mode_banked_rf rf_checker u_rf_checker (
  .clk(clk), .rst_n(rst_n), .illegal(illegal_mode_o),
  .w32_en(w32_en_i), .w32_idx(w32_idx_i), .x_we(x_we_i),
  .ra_idx(ra_idx_i), .ra_data(ra_data_o), .mem(mem_w)
);

// File: tb/mode_banked_rf_bench.sv
module mode_banked_rf_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  mode_i = 5'h10;
  logic        illegal_mode_o;
  logic [3:0]  ra_idx_i = '0, rb_idx_i = '0, w32_idx_i = '0;
  logic [31:0] ra_data_o, rb_data_o, w32_data_i = '0;
  logic        w32_en_i = 1'b0, x_we_i = 1'b0;
  logic [4:0]  x_idx_i = '0;
  logic [63:0] x_wdata_i = '0, x_rdata_o;

  int vecs = 0;
  int miss = 0;
  logic [63:0] model [32];

  always #4 clk = ~clk;

  mode_banked_rf u_mode_banked_rf (.*);

  localparam logic [4:0] MODES [8] = '{5'h10, 5'h11, 5'h12, 5'h13,
                                       5'h17, 5'h1A, 5'h1B, 5'h1F};

  function automatic bit is_legal(input logic [4:0] m);
    foreach (MODES[i]) if (MODES[i] == m) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int ref_slot(input logic [4:0] m, input int r);
    if (r == 15) return 31;
    if (r < 8) return r;
    if (m == 5'h11) return r + 16;
    if (r < 13) return r;
    case (m)
      5'h1A:   return (r == 13) ? 15 : 14;
      5'h12:   return r + 3;
      5'h13:   return r + 5;
      5'h17:   return r + 7;
      5'h1B:   return r + 9;
      default: return r;
    endcase
  endfunction

  function automatic string req_of(input logic [4:0] m, input int r);
    if (r < 8) return "R1";
    if (r < 13 || m == 5'h11) return "R2";
    return "R3";
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic x_write(input int slot, input logic [63:0] d);
    @(negedge clk);
    x_idx_i = 5'(slot); x_wdata_i = d; x_we_i = 1'b1;
    @(negedge clk);
    x_we_i = 1'b0;
    model[slot] = d;
  endtask

  task automatic a_write(input logic [4:0] m, input int r, input logic [31:0] d);
    @(negedge clk);
    mode_i = m; w32_idx_i = 4'(r); w32_data_i = d; w32_en_i = 1'b1;
    @(negedge clk);
    w32_en_i = 1'b0;
    if (is_legal(m)) model[ref_slot(m, r)] = {32'h0, d};
  endtask

  task automatic x_check(input int slot, input string req);
    @(negedge clk);
    x_idx_i = 5'(slot);
    #1 chk(req, x_rdata_o, model[slot]);
  endtask

  task automatic t_reset(input string tag);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    foreach (model[i]) model[i] = '0;
    for (int s = 0; s < 32; s++) x_check(s, tag);
  endtask

  task automatic t_sweep;
    for (int s = 0; s < 32; s++) x_write(s, 64'hFFFF_FFFF_0000_0000 | 64'(s));
    foreach (MODES[mi]) begin
      for (int r = 0; r < 15; r++)
        a_write(MODES[mi], r, 32'hC0DE_0000 | (32'(MODES[mi]) << 8) | 32'(r));
      for (int r = 0; r < 15; r++) begin
        @(negedge clk);
        mode_i = MODES[mi]; ra_idx_i = 4'(r);
        #1 chk(req_of(MODES[mi], r), {32'h0, ra_data_o},
               {32'h0, model[ref_slot(MODES[mi], r)][31:0]});
      end
    end
    for (int s = 0; s < 31; s++) x_check(s, "R7");
  endtask

  task automatic t_pc;
    a_write(5'h13, 15, 32'h8000_1000);
    x_check(31, "R4");
    x_write(31, 64'h0000_0001_2345_6788);
    @(negedge clk);
    mode_i = 5'h1B; rb_idx_i = 4'd15;
    #1 chk("R4", {32'h0, rb_data_o}, 64'h0000_0000_2345_6788);
  endtask

  task automatic t_illegal;
    logic [4:0] bad [4] = '{5'h00, 5'h14, 5'h1E, 5'h0F};
    foreach (MODES[i]) begin
      @(negedge clk); mode_i = MODES[i];
      #1 chk("R5", {63'h0, illegal_mode_o}, 64'h0);
    end
    foreach (bad[i]) begin
      @(negedge clk); mode_i = bad[i];
      #1 chk("R5", {63'h0, illegal_mode_o}, 64'h1);
      a_write(bad[i], 3, 32'hDEAD_0000 | 32'(i));
      a_write(bad[i], 15, 32'hDEAD_FFFF);
      x_check(3, "R6");
      x_check(31, "R6");
      @(negedge clk); mode_i = bad[i]; ra_idx_i = 4'd3; rb_idx_i = 4'd15;
      #1 chk("R6", {ra_data_o, rb_data_o}, 64'h0);
    end
  endtask

  task automatic t_rdw;
    a_write(5'h10, 2, 32'h1111_1111);
    @(negedge clk);
    mode_i = 5'h10; w32_idx_i = 4'd2; w32_data_i = 32'h2222_2222; w32_en_i = 1'b1;
    ra_idx_i = 4'd2;
    #1 chk("R8", {32'h0, ra_data_o}, 64'h1111_1111);
    @(negedge clk);
    w32_en_i = 1'b0; model[2] = 64'h2222_2222;
    #1 chk("R8", {32'h0, ra_data_o}, 64'h2222_2222);
  endtask

  task automatic t_conflict;
    @(negedge clk);
    mode_i = 5'h10; w32_idx_i = 4'd5; w32_data_i = 32'h5555_5555; w32_en_i = 1'b1;
    x_idx_i = 5'd5; x_wdata_i = 64'hABCD_0123_4567_89EF; x_we_i = 1'b1;
    @(negedge clk);
    w32_en_i = 1'b0; x_we_i = 1'b0;
    model[5] = 64'hABCD_0123_4567_89EF;
    x_check(5, "R9");
  endtask

  task automatic t_switch;
    a_write(5'h12, 13, 32'h1300_0012);
    a_write(5'h13, 13, 32'h1300_0013);
    @(negedge clk);
    mode_i = 5'h12; ra_idx_i = 4'd13;
    #1 chk("R11", {32'h0, ra_data_o}, 64'h1300_0012);
    #2 mode_i = 5'h13;
    #1 chk("R11", {32'h0, ra_data_o}, 64'h1300_0013);
    x_check(16, "R11");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miss++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    t_reset("R10");
    t_sweep;
    t_pc;
    t_illegal;
    t_rdw;
    t_conflict;
    t_switch;
    t_reset("R10");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule